// File: doc/BRIEF.md
# Address Translation Unit with Hardware Page Walk

This block turns the virtual addresses of a processor load/store port into physical addresses. Recent translations sit in a small fully associative cache of entries. When a request hits, the result comes back one lookup cycle later. When a request misses, the block reads a single-level page table in memory on its own. It then loads the fetched entry into the cache and repeats the lookup.

Pages are 4 KB, so the low 12 bits of the address pass through unchanged. The upper virtual bits form the virtual page number (VPN). The memory word address of a page table entry is the base input placed above the VPN. The two fields are joined, never added.

Every cached entry holds:
- a validity flag;
- a 2-bit rights code;
- a referenced flag, which drives an approximate least-recently-used choice of victim;
- a dirty flag, set by permitted writes and reported when a valid entry is replaced.

A table entry marked not present gives a page fault. An access that its rights forbid gives a protection fault. A flush input clears the whole cache in one cycle.

Top module: `xlat_unit`

## Requirements
- R1: After reset, `req_ready_o` is 1, `rsp_valid_o`, `mem_req_o` and `evict_valid_o` are 0, and no entry is valid, so the first access to any page starts a walk.
- R2: A successful translation returns `rsp_paddr_o` = {physical page number, `req_vaddr_i[11:0]`} with both fault flags 0. Any faulting response returns `rsp_paddr_o` = 0.
- R3: On a miss, `mem_req_o` is high for exactly one cycle, two cycles after the accepting edge, with `mem_addr_o` = {`ptbase_i`, VPN}. After `mem_rvalid_i` is seen, the cache is filled and the lookup is retried. The response is visible 3 cycles after the edge that samples `mem_rvalid_i`.
- R4: Page table entry layout on `mem_rdata_i`: bit 0 present, bits 2:1 rights, bits 16:3 physical page number. An entry with bit 0 clear is not cached. It gives `rsp_pfault_o` = 1 one cycle after the sampling edge, and a repeated access walks again.
- R5: A hit makes no memory read, and `rsp_valid_o` is high for one cycle starting at the second rising edge after the accepting edge.
- R6: Rights code 10 allows reads and writes, and 01 allows reads only. Codes 00 and 11 allow nothing. A forbidden access returns `rsp_prot_o` = 1.
- R7: A permitted write sets the entry's dirty flag. A forbidden write, and a fill, leave it clear. The flag is given on `evict_dirty_o` when the entry is replaced.
- R8: The victim for a fill is chosen in this order:
  - the lowest-index invalid entry;
  - otherwise the lowest-index entry whose referenced flag is clear;
  - otherwise entry 0, with every referenced flag cleared.

  When the victim was valid, `evict_valid_o` is high for the fill cycle, with its VPN and dirty flag.
- R9: Only a permitted hit sets an entry's referenced flag. A fill clears it, and a faulting hit leaves it unchanged.
- R10: `flush_i` high at a rising edge makes every entry invalid from the next cycle, so later accesses walk again.
- R11: At most one valid entry matches any VPN, and a hit returns that entry's translation.
- R12: Only one request is outstanding. `req_ready_o` is low from the accepting edge until the response cycle ends, and it is high again in the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptbase_i | input | 6 | Page table base, the upper part of the entry address |
| flush_i | input | 1 | Invalidate all cached entries |
| req_valid_i | input | 1 | Translation request present |
| req_write_i | input | 1 | Request is a write |
| req_vaddr_i | input | 32 | Virtual address |
| req_ready_o | output | 1 | Block can accept a request |
| rsp_valid_o | output | 1 | Response present, one cycle |
| rsp_paddr_o | output | 26 | Physical address, 0 on a fault |
| rsp_pfault_o | output | 1 | Page not present |
| rsp_prot_o | output | 1 | Access forbidden by rights |
| mem_req_o | output | 1 | Page table read request, one-cycle pulse |
| mem_addr_o | output | 26 | Word address of the page table entry |
| mem_rvalid_i | input | 1 | Page table read data valid |
| mem_rdata_i | input | 17 | Page table entry |
| evict_valid_o | output | 1 | A valid entry is being replaced |
| evict_vpn_o | output | 20 | VPN of the replaced entry |
| evict_dirty_o | output | 1 | Dirty flag of the replaced entry |

## Verification
On every cycle, the assertions check the following:
- no VPN matches more than one entry;
- a flush leaves nothing valid;
- a dirty flag only rises through a permitted write;
- the memory request is a single-cycle pulse;
- page faults come only straight after a walk;
- free entries are used before occupied ones;
- the offset passes through unchanged.

The victim order under mixed referenced flags, and the clearing of all of them when every flag is set, can only be shown by the bench's scenarios. The same holds for the latencies of hits, walks and faults, and for dirty flags reaching the eviction port.

// File: rtl/xlat_pkg.sv
// Shared types for the address translation unit.
// Assumes 2-bit rights codes and a page table entry laid out as
// {ppn, rights[1:0], present}.
package xlat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FETCH,
        ST_WAIT,
        ST_FILL,
        ST_RESP
    } walk_state_e;

    typedef enum logic [1:0] {
        RIGHTS_NONE = 2'b00,
        RIGHTS_RO   = 2'b01,
        RIGHTS_RW   = 2'b10,
        RIGHTS_RSV  = 2'b11
    } rights_e;

    localparam int PTE_PRESENT_BIT = 0;
    localparam int PTE_RIGHTS_LSB  = 1;
    localparam int PTE_PPN_LSB     = 3;

    // Decide whether a rights code allows the access kind.
    function automatic logic rights_permit(input logic [1:0] rights, input logic wr);
        return (rights == RIGHTS_RW) || ((rights == RIGHTS_RO) && !wr);
    endfunction

endpackage

// File: rtl/xlat_cam.sv
// Fully associative entry store with parallel VPN match.
// Holds VPN, PPN, rights, valid, referenced and dirty per entry.
// Assumes fill and touch never occur in the same cycle; flush wins over both.
module xlat_cam #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 14,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [PPN_W-1:0]   hit_ppn,
    output logic [1:0]         hit_rights,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [PPN_W-1:0]   fill_ppn,
    input  logic [1:0]         fill_rights,
    input  logic               clr_refs,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic               touch_write,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [VPN_W-1:0]   rd_vpn,
    output logic               rd_dirty,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [ENTRIES-1:0] ref_vec
);

    logic [VPN_W-1:0]   vpn_q    [ENTRIES];
    logic [PPN_W-1:0]   ppn_q    [ENTRIES];
    logic [1:0]         rights_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] ref_q;
    logic [ENTRIES-1:0] dirty_q;
    logic [ENTRIES-1:0] match_vec;

    // Valid flags: cleared by reset and flush, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[fill_idx] <= 1'b1;
        end
    end

    // Referenced flags: set by permitted hits, cleared by fills and by the all-set rule.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ref_q <= '0;
        end else if (fill_en) begin
            if (clr_refs) begin
                ref_q <= '0;
            end
            ref_q[fill_idx] <= 1'b0;
        end else if (touch_en) begin
            ref_q[touch_idx] <= 1'b1;
        end
    end

    // Dirty flags: set by permitted writes, cleared when an entry is refilled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= '0;
        end else if (fill_en) begin
            dirty_q[fill_idx] <= 1'b0;
        end else if (touch_en && touch_write) begin
            dirty_q[touch_idx] <= 1'b1;
        end
    end

    // Translation payload written on a fill.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            vpn_q[fill_idx]    <= fill_vpn;
            ppn_q[fill_idx]    <= fill_ppn;
            rights_q[fill_idx] <= fill_rights;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign match_vec[g] = valid_q[g] && (vpn_q[g] == lk_vpn);

        // R7: a dirty flag only rises after a permitted write to this entry.
        a_r7_dirty_from_write: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dirty_q[g]) |-> $past(touch_en && touch_write && (touch_idx == IDX_W'(g))));
    end

    // OR-combine the matching entry's fields; at most one entry matches.
    always_comb begin
        hit_idx    = '0;
        hit_ppn    = '0;
        hit_rights = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) begin
                hit_idx    = hit_idx | IDX_W'(i);
                hit_ppn    = hit_ppn | ppn_q[i];
                hit_rights = hit_rights | rights_q[i];
            end
        end
    end

    assign hit       = |match_vec;
    assign rd_vpn    = vpn_q[rd_idx];
    assign rd_dirty  = dirty_q[rd_idx];
    assign valid_vec = valid_q;
    assign ref_vec   = ref_q;

    // R11: no VPN may match two entries.
    a_r11_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    // R10: a flush leaves every entry invalid.
    a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));

endmodule

// File: rtl/xlat_victim.sv
// Victim selection for fills. Prefers the lowest invalid entry, then the lowest
// entry with its referenced flag clear, else entry 0 with a request to clear all flags.
// Purely combinational.
module xlat_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] ref_vec,
    output logic [IDX_W-1:0]   victim_idx,
    output logic               clr_refs
);

    logic found;

    // Priority search over the two flag vectors.
    always_comb begin
        victim_idx = '0;
        clr_refs   = 1'b0;
        found      = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && !valid_vec[i]) begin
                victim_idx = IDX_W'(i);
                found      = 1'b1;
            end
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && !ref_vec[i]) begin
                victim_idx = IDX_W'(i);
                found      = 1'b1;
            end
        end
        if (!found) begin
            victim_idx = '0;
            clr_refs   = 1'b1;
        end
    end

endmodule

// File: rtl/xlat_walker.sv
// Request sequencer: accepts one request, looks it up, walks the page table on
// a miss, requests a fill, retries, and presents a one-cycle response.
// Assumes the memory returns exactly one mem_rvalid per mem_req.
module xlat_walker
    import xlat_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 26,
    parameter int OFF_W   = 12,
    parameter int PTB_W   = 6,
    parameter int IDX_W   = 3,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PPN_W  = PA_W - OFF_W,
    localparam int PTE_W  = PPN_W + 3,
    localparam int MEM_AW = PTB_W + VPN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTB_W-1:0]  ptbase_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [VA_W-1:0]   req_vaddr_i,
    output logic              req_ready_o,
    output logic              rsp_valid_o,
    output logic [PA_W-1:0]   rsp_paddr_o,
    output logic              rsp_pfault_o,
    output logic              rsp_prot_o,
    output logic              mem_req_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [PTE_W-1:0]  mem_rdata_i,
    output logic [VPN_W-1:0]  lk_vpn_o,
    input  logic              hit_i,
    input  logic [IDX_W-1:0]  hit_idx_i,
    input  logic [PPN_W-1:0]  hit_ppn_i,
    input  logic [1:0]        hit_rights_i,
    output logic              touch_en_o,
    output logic [IDX_W-1:0]  touch_idx_o,
    output logic              touch_write_o,
    output logic              fill_en_o,
    output logic [PPN_W-1:0]  fill_ppn_o,
    output logic [1:0]        fill_rights_o
);

    walk_state_e      state_q, state_d;
    logic [VA_W-1:0]  vaddr_q;
    logic             write_q;
    logic [PTE_W-1:0] pte_q;
    logic [PA_W-1:0]  paddr_q;
    logic             pfault_q;
    logic             prot_q;
    logic             permit;

    assign permit = rights_permit(hit_rights_i, write_q);

    // Next-state selection for the walk sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (req_valid_i) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = hit_i ? ST_RESP : ST_FETCH;
            ST_FETCH:  state_d = ST_WAIT;
            ST_WAIT:   if (mem_rvalid_i) state_d = mem_rdata_i[PTE_PRESENT_BIT] ? ST_FILL : ST_RESP;
            ST_FILL:   state_d = ST_LOOKUP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the request on acceptance and the table entry on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            write_q <= 1'b0;
            pte_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid_i) begin
                vaddr_q <= req_vaddr_i;
                write_q <= req_write_i;
            end
            if (state_q == ST_WAIT && mem_rvalid_i) begin
                pte_q <= mem_rdata_i;
            end
        end
    end

    // Response registers, loaded on a hit or on a not-present table entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q  <= '0;
            pfault_q <= 1'b0;
            prot_q   <= 1'b0;
        end else if (state_q == ST_LOOKUP && hit_i) begin
            paddr_q  <= permit ? {hit_ppn_i, vaddr_q[OFF_W-1:0]} : '0;
            pfault_q <= 1'b0;
            prot_q   <= !permit;
        end else if (state_q == ST_WAIT && mem_rvalid_i && !mem_rdata_i[PTE_PRESENT_BIT]) begin
            paddr_q  <= '0;
            pfault_q <= 1'b1;
            prot_q   <= 1'b0;
        end
    end

    assign req_ready_o   = (state_q == ST_IDLE);
    assign rsp_valid_o   = (state_q == ST_RESP);
    assign rsp_paddr_o   = paddr_q;
    assign rsp_pfault_o  = pfault_q;
    assign rsp_prot_o    = prot_q;
    assign mem_req_o     = (state_q == ST_FETCH);
    assign mem_addr_o    = {ptbase_i, vaddr_q[VA_W-1:OFF_W]};
    assign lk_vpn_o      = vaddr_q[VA_W-1:OFF_W];
    assign touch_en_o    = (state_q == ST_LOOKUP) && hit_i && permit;
    assign touch_idx_o   = hit_idx_i;
    assign touch_write_o = write_q;
    assign fill_en_o     = (state_q == ST_FILL);
    assign fill_ppn_o    = pte_q[PTE_PPN_LSB +: PPN_W];
    assign fill_rights_o = pte_q[PTE_RIGHTS_LSB +: 2];

    // R3: the table read request is a single-cycle pulse.
    a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    // R4: a page fault response follows directly on a table read.
    a_r4_pfault_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_pfault_o) |-> $past(state_q == ST_WAIT));

    // R12: the block is ready again right after a response.
    a_r12_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> req_ready_o);

    // R2: the page offset passes through on a successful translation.
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_pfault_o && !rsp_prot_o) |->
            (rsp_paddr_o[OFF_W-1:0] == vaddr_q[OFF_W-1:0]));

endmodule

// File: rtl/xlat_unit.sv
// Top of the address translation unit: entry store, victim picker and walk
// sequencer. Page table entry address is {ptbase_i, vpn}. Eviction information
// is presented during the fill cycle when the chosen victim was valid.
module xlat_unit #(
    parameter int VA_W    = 32,
    parameter int PA_W    = 26,
    parameter int OFF_W   = 12,
    parameter int PTB_W   = 6,
    parameter int ENTRIES = 8,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PPN_W  = PA_W - OFF_W,
    localparam int PTE_W  = PPN_W + 3,
    localparam int MEM_AW = PTB_W + VPN_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTB_W-1:0]  ptbase_i,
    input  logic              flush_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [VA_W-1:0]   req_vaddr_i,
    output logic              req_ready_o,
    output logic              rsp_valid_o,
    output logic [PA_W-1:0]   rsp_paddr_o,
    output logic              rsp_pfault_o,
    output logic              rsp_prot_o,
    output logic              mem_req_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [PTE_W-1:0]  mem_rdata_i,
    output logic              evict_valid_o,
    output logic [VPN_W-1:0]  evict_vpn_o,
    output logic              evict_dirty_o
);

    logic [VPN_W-1:0]   lk_vpn;
    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [PPN_W-1:0]   hit_ppn;
    logic [1:0]         hit_rights;
    logic               touch_en;
    logic [IDX_W-1:0]   touch_idx;
    logic               touch_write;
    logic               fill_en;
    logic [PPN_W-1:0]   fill_ppn;
    logic [1:0]         fill_rights;
    logic [IDX_W-1:0]   victim_idx;
    logic               clr_refs;
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] ref_vec;
    logic [VPN_W-1:0]   rd_vpn;
    logic               rd_dirty;

    xlat_walker #(
        .VA_W (VA_W),
        .PA_W (PA_W),
        .OFF_W(OFF_W),
        .PTB_W(PTB_W),
        .IDX_W(IDX_W)
    ) u_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .ptbase_i     (ptbase_i),
        .req_valid_i  (req_valid_i),
        .req_write_i  (req_write_i),
        .req_vaddr_i  (req_vaddr_i),
        .req_ready_o  (req_ready_o),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_paddr_o  (rsp_paddr_o),
        .rsp_pfault_o (rsp_pfault_o),
        .rsp_prot_o   (rsp_prot_o),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_rdata_i  (mem_rdata_i),
        .lk_vpn_o     (lk_vpn),
        .hit_i        (hit),
        .hit_idx_i    (hit_idx),
        .hit_ppn_i    (hit_ppn),
        .hit_rights_i (hit_rights),
        .touch_en_o   (touch_en),
        .touch_idx_o  (touch_idx),
        .touch_write_o(touch_write),
        .fill_en_o    (fill_en),
        .fill_ppn_o   (fill_ppn),
        .fill_rights_o(fill_rights)
    );

    xlat_cam #(
        .ENTRIES(ENTRIES),
        .VPN_W  (VPN_W),
        .PPN_W  (PPN_W)
    ) u_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush_i),
        .lk_vpn     (lk_vpn),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .hit_ppn    (hit_ppn),
        .hit_rights (hit_rights),
        .fill_en    (fill_en),
        .fill_idx   (victim_idx),
        .fill_vpn   (lk_vpn),
        .fill_ppn   (fill_ppn),
        .fill_rights(fill_rights),
        .clr_refs   (clr_refs),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .touch_write(touch_write),
        .rd_idx     (victim_idx),
        .rd_vpn     (rd_vpn),
        .rd_dirty   (rd_dirty),
        .valid_vec  (valid_vec),
        .ref_vec    (ref_vec)
    );

    xlat_victim #(
        .ENTRIES(ENTRIES)
    ) u_victim (
        .valid_vec (valid_vec),
        .ref_vec   (ref_vec),
        .victim_idx(victim_idx),
        .clr_refs  (clr_refs)
    );

    assign evict_valid_o = fill_en && valid_vec[victim_idx];
    assign evict_vpn_o   = rd_vpn;
    assign evict_dirty_o = rd_dirty;

    // R8: while a free entry exists, a fill never displaces a valid one.
    a_r8_prefer_free: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !(&valid_vec)) |-> !evict_valid_o);

endmodule

// File: tb/xlat_unit_tb.sv
// Self-checking bench with a behavioural reference model of the cache and page table.
module xlat_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  ptbase;
    logic        flush;
    logic        req_valid;
    logic        req_write;
    logic [31:0] req_vaddr;
    logic        req_ready;
    logic        rsp_valid;
    logic [25:0] rsp_paddr;
    logic        rsp_pfault;
    logic        rsp_prot;
    logic        mem_req;
    logic [25:0] mem_addr;
    logic        mem_rvalid;
    logic [16:0] mem_rdata;
    logic        evict_valid;
    logic [19:0] evict_vpn;
    logic        evict_dirty;

    int checks = 0;
    int errors = 0;
    int mem_lat = 1;
    int seen_req = 0;
    int seen_addr = 0;

    // reference model state
    int m_vpn [8];
    int m_ppn [8];
    int m_rt  [8];
    bit m_v   [8];
    bit m_ref [8];
    bit m_d   [8];
    int pt [int];

    always #10 clk = ~clk;

    xlat_unit u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ptbase_i     (ptbase),
        .flush_i      (flush),
        .req_valid_i  (req_valid),
        .req_write_i  (req_write),
        .req_vaddr_i  (req_vaddr),
        .req_ready_o  (req_ready),
        .rsp_valid_o  (rsp_valid),
        .rsp_paddr_o  (rsp_paddr),
        .rsp_pfault_o (rsp_pfault),
        .rsp_prot_o   (rsp_prot),
        .mem_req_o    (mem_req),
        .mem_addr_o   (mem_addr),
        .mem_rvalid_i (mem_rvalid),
        .mem_rdata_i  (mem_rdata),
        .evict_valid_o(evict_valid),
        .evict_vpn_o  (evict_vpn),
        .evict_dirty_o(evict_dirty)
    );

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int pt_addr(input int vpn);
        return (int'(ptbase) << 20) | vpn;
    endfunction

    function automatic int mk_pte(input int ppn, input int rt, input int present);
        return (ppn << 3) | (rt << 1) | present;
    endfunction

    // Memory responder: one read data beat mem_lat cycles after each request.
    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (mem_req) begin
                int a;
                a = int'(mem_addr);
                seen_req++;
                seen_addr = a;
                repeat (mem_lat) @(negedge clk);
                mem_rvalid = 1'b1;
                mem_rdata  = pt.exists(a) ? 17'(pt[a]) : 17'h0;
            end
        end
    end

    // Apply an access to a model entry; returns expected paddr and prot flag.
    task automatic model_use(input int idx, input bit wr, input int off, output int pa, output bit prot);
        bit ok;
        ok = (m_rt[idx] == 2) || (m_rt[idx] == 1 && !wr);
        if (ok) begin
            m_ref[idx] = 1'b1;
            if (wr) m_d[idx] = 1'b1;
            pa = (m_ppn[idx] << 12) | off;
            prot = 1'b0;
        end else begin
            pa = 0;
            prot = 1'b1;
        end
    endtask

    task automatic access(input bit wr, input int va, input string scen);
        int  vpn, off, hidx, vic, pte, e_pa, e_lat, e_walk, e_addr, cyc, req0;
        bit  e_pf, e_prot, e_ev, e_evd, busy_ok;
        int  e_evvpn, ev_n, ev_vpn;
        bit  ev_d;
        vpn = va >>> 12 & 32'hFFFFF;
        off = va & 32'hFFF;
        hidx = -1;
        e_pf = 0; e_prot = 0; e_pa = 0; e_ev = 0; e_evd = 0; e_evvpn = 0; e_addr = 0;
        for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == vpn) hidx = i;
        if (hidx >= 0) begin
            e_walk = 0;
            e_lat  = 2;
            model_use(hidx, wr, off, e_pa, e_prot);
        end else begin
            e_walk = 1;
            e_addr = pt_addr(vpn);
            pte = pt.exists(e_addr) ? pt[e_addr] : 0;
            if ((pte & 1) == 0) begin
                e_pf  = 1;
                e_lat = 3 + mem_lat;
            end else begin
                vic = -1;
                for (int i = 0; i < 8; i++) if (vic < 0 && !m_v[i]) vic = i;
                for (int i = 0; i < 8; i++) if (vic < 0 && !m_ref[i]) vic = i;
                if (vic < 0) begin
                    vic = 0;
                    for (int i = 0; i < 8; i++) m_ref[i] = 1'b0;
                end
                if (m_v[vic]) begin
                    e_ev = 1; e_evvpn = m_vpn[vic]; e_evd = m_d[vic];
                end
                m_v[vic] = 1; m_vpn[vic] = vpn; m_ppn[vic] = (pte >> 3) & 32'h3FFF;
                m_rt[vic] = (pte >> 1) & 3; m_ref[vic] = 0; m_d[vic] = 0;
                e_lat = 5 + mem_lat;
                model_use(vic, wr, off, e_pa, e_prot);
            end
        end

        @(negedge clk);
        chk(req_ready == 1'b1, "R12", {scen, " ready before request"}, req_ready, 1);
        req_valid = 1'b1;
        req_write = wr;
        req_vaddr = va;
        req0 = seen_req;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        ev_n = 0; ev_vpn = 0; ev_d = 0;
        busy_ok = 1;
        while (!rsp_valid && cyc < 60) begin
            if (req_ready) busy_ok = 0;
            if (evict_valid) begin
                ev_n++; ev_vpn = int'(evict_vpn); ev_d = evict_dirty;
            end
            @(negedge clk);
            cyc++;
        end
        chk(busy_ok, "R12", {scen, " ready low while busy"}, busy_ok, 1);
        chk(cyc == e_lat, e_walk ? (e_pf ? "R4" : "R3") : "R5", {scen, " latency"}, cyc, e_lat);
        chk(rsp_paddr == 26'(e_pa), "R2", {scen, " paddr"}, rsp_paddr, e_pa);
        chk(rsp_pfault == e_pf, "R4", {scen, " page fault"}, rsp_pfault, e_pf);
        chk(rsp_prot == e_prot, "R6", {scen, " protection fault"}, rsp_prot, e_prot);
        chk(seen_req - req0 == e_walk, "R3", {scen, " walk count"}, seen_req - req0, e_walk);
        if (e_walk == 1)
            chk(seen_addr == e_addr, "R3", {scen, " walk address"}, seen_addr, e_addr);
        chk(ev_n == int'(e_ev), "R8", {scen, " eviction count"}, ev_n, e_ev);
        if (e_ev) begin
            chk(ev_vpn == e_evvpn, "R8", {scen, " evicted vpn"}, ev_vpn, e_evvpn);
            chk(ev_d == e_evd, "R7", {scen, " evicted dirty"}, ev_d, e_evd);
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R12", {scen, " one-cycle response"},
            {rsp_valid, req_ready}, 2'b01);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 8; i++) begin
            m_v[i] = 0; m_ref[i] = 0;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; ptbase = 6'h2A; flush = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0;
        for (int i = 0; i < 8; i++) begin
            m_v[i] = 0; m_ref[i] = 0; m_d[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_rt[i] = 0;
        end
        // page table at base 0x2A
        pt[pt_addr(1)]  = mk_pte(14'h101, 2, 1);
        pt[pt_addr(2)]  = mk_pte(14'h202, 1, 1);
        pt[pt_addr(3)]  = mk_pte(14'h303, 0, 1);
        pt[pt_addr(4)]  = mk_pte(14'h404, 3, 1);
        for (int p = 5; p <= 12; p++) pt[pt_addr(p)] = mk_pte(14'h1000 + p, 2, 1);
        pt[pt_addr(32'h77)] = mk_pte(14'h3FFF, 2, 0);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", rsp_valid, 0);
        chk(mem_req == 1'b0 && evict_valid == 1'b0, "R1", "idle memory and eviction",
            {mem_req, evict_valid}, 0);

        mem_lat = 1;
        access(0, 32'h0000_1234, "R1 first access walks");
        access(0, 32'h0000_1ABC, "R11 hit single entry");
        access(1, 32'h0000_1004, "R7 write hit");
        mem_lat = 3;
        access(0, 32'h0000_2010, "R6 read-only read");
        access(1, 32'h0000_2020, "R6 read-only write");
        access(0, 32'h0000_3000, "R6 no-access code");
        access(0, 32'h0000_4FFF, "R6 reserved code");
        access(0, 32'h0007_7123, "R4 not present");
        access(1, 32'h0007_7123, "R4 not present again");
        mem_lat = 2;
        for (int p = 5; p <= 8; p++) access(0, p << 12 | 32'h40, "R8 fill free");
        access(0, 32'h0000_9000, "R9 faulting hits keep ref clear");
        access(1, 32'h0000_A008, "R8 second ref-clear victim");
        access(0, 32'h0000_B00C, "R8 all ref set clears and takes entry 0");
        access(0, 32'h0000_2FFF, "R9 ref set by permitted hit");
        access(0, 32'h0000_C000, "R8 victim after clear");
        do_flush();
        access(0, 32'h0000_2FFF, "R10 walk after flush");
        ptbase = 6'h15;
        pt[pt_addr(32'h20)] = mk_pte(14'h2ABC, 2, 1);
        access(1, 32'h0002_0555, "R3 base concatenation");
        access(0, 32'h0002_0556, "R11 hit after base change");
        finish_run();
    end

endmodule